// File: doc/BRIEF.md
# ECC Error Monitor and Controller

This block sits beside a set of parallel SECDED lanes on a memory read/write path. Each lane guards 64 data bits with a 72-bit codeword. On every read the lanes report what their decoders found: a flag for a single-bit error that was corrected, a flag for a double-bit error that could not be corrected, and the check-bit syndrome. The read carries one word address shared by all lanes. The monitor turns these reports into several results:

- a per-lane error flag that travels with the returned data;
- two saturating event counters with programmable thresholds;
- sticky, maskable interrupt sources;
- a capture of the details of one error, either the first one seen or the latest one.

Software can also make the block corrupt one or two chosen check bits on writes. The write-side encoders apply this mask, so a test can exercise both the correction path and the detection path.

Software reaches every setting and every status field through a simple 32-bit register port. A write takes effect at the next clock edge. Read data is combinational from the word address. All registers reset to zero. The encoders and decoders are not part of this block.

Top module: `ecc_err_monitor`

## Requirements
- R1: The single-error counter (offset 0x5) adds, on each read, the number of lanes that flag a single-bit error without a double-bit flag. The double-error counter (offset 0x6) adds the number of lanes that flag a double-bit error. Only cycles with the read strobe high count. Both counters saturate at all ones. Any write to offset 0x7 zeroes both counters, and that clear wins over events in the same cycle.
- R2: Bit i of `word_err` is high in the same cycle as the read strobe whenever lane i flags a double-bit error. It is low whenever the read strobe is low.
- R3: The pending register (offset 0x1) has four bits. Bit 0 is a single-bit event and bit 1 is a double-bit event. Each bit is sticky. Writing a one to a bit clears it, and a new event in the same cycle wins over the clear.
- R4: Pending bit 2 sets on the update in which the single-error count goes from at most its threshold (offset 0x3) to above it. Pending bit 3 does the same for the double-error count and its threshold (offset 0x4).
- R5: `irq` is the OR of all pending bits whose enable bit is one in the mask register (offset 0x2, bits 3:0).
- R6: Control bit 0 (offset 0x0) selects the capture mode. With 0, the capture stays locked once its valid flag is set, until software writes a one to bit 0 of offset 0x9. With 1, every error overwrites the capture.
- R7: The capture holds the read address (offset 0x8) and an info word (offset 0x9): bit 0 valid, bit 1 type (1 = double-bit), bits 15:8 syndrome, bits 23:16 lane. A double-bit report outranks a single-bit report, and among equal reports the lowest lane wins.
- R8: Control bit 1 enables corruption. Control bit 2 selects two flipped bits instead of one. Bits 10:8 hold the first check-bit position and bits 14:12 hold the second. `corrupt_mask` has a one at each selected position while corruption is enabled, so equal positions give a single bit. The mask is all zero when corruption is disabled.
- R9: Control, mask and threshold registers read back the bits written, limited to their defined fields. Every register reads zero after reset. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read word strobe; the lane reports are valid |
| rd_addr | input | ADDR_W | Address of the read word |
| lane_sbe | input | N_LANES | Per-lane corrected single-bit error flag |
| lane_dbe | input | N_LANES | Per-lane uncorrectable double-bit error flag |
| lane_syn | input | N_LANES*(CODE_W-DATA_W) | Per-lane syndromes, lane 0 in the low bits |
| word_err | output | N_LANES | Per-lane uncorrectable flag returned with the read data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| corrupt_en | output | 1 | Corruption active toward the write encoders |
| corrupt_mask | output | CODE_W-DATA_W | Check bits to flip on writes |

## Verification
The bench builds the block with three lanes, a 16-bit address and 4-bit counters. Three lanes make same-cycle priority cases reachable: a double-bit report outranking a single-bit one, and a tie between two lanes. The 4-bit counters saturate at 15 after only a few three-lane reads, and the value the 16-bit threshold write leaves in the narrow threshold field shows that readback keeps only the defined bits. The default check-bit count of eight lets the corruption tests reach both the low and the high check-bit positions.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;

   localparam logic [3:0] RA_CTRL  = 4'h0;
   localparam logic [3:0] RA_ISTAT = 4'h1;
   localparam logic [3:0] RA_IMASK = 4'h2;
   localparam logic [3:0] RA_STHR  = 4'h3;
   localparam logic [3:0] RA_DTHR  = 4'h4;
   localparam logic [3:0] RA_SCNT  = 4'h5;
   localparam logic [3:0] RA_DCNT  = 4'h6;
   localparam logic [3:0] RA_CCLR  = 4'h7;
   localparam logic [3:0] RA_CADDR = 4'h8;
   localparam logic [3:0] RA_CINFO = 4'h9;

   localparam int IRQ_SRC_N = 4;

   // pending-bit indices
   typedef enum logic [1:0] {
      PB_SBE  = 2'd0,
      PB_DBE  = 2'd1,
      PB_SCRS = 2'd2,
      PB_DCRS = 2'd3
   } pend_bit_e;

   // control field bit positions
   localparam int CB_RECENT = 0;
   localparam int CB_COR_ON = 1;
   localparam int CB_COR_DB = 2;
   localparam int CB_POS_A  = 8;
   localparam int CB_POS_B  = 12;

endpackage

// File: rtl/ecc_err_count.sv
module ecc_err_count #(
   parameter int N_IN  = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  inc,
   input  logic             clr,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] count,
   output logic             crossed
);

   localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

   logic [CNT_W:0]   sum;
   logic [CNT_W:0]   raw;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      sum = '0;
      for (int i = 0; i < N_IN; i++) begin
         sum = sum + (CNT_W+1)'(inc[i]);
      end
      raw = {1'b0, count} + sum;
      nxt = (raw > MAX_EXT) ? {CNT_W{1'b1}} : raw[CNT_W-1:0];
   end

   assign crossed = !clr && (count <= thresh) && (nxt > thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else          count <= nxt;
   end

endmodule

// File: rtl/ecc_err_select.sv
module ecc_err_select #(
   parameter int N_LANES = 4,
   parameter int SYN_W   = 8,
   localparam int LANE_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
   input  logic [N_LANES-1:0]       sbe,
   input  logic [N_LANES-1:0]       dbe,
   input  logic [N_LANES*SYN_W-1:0] syn_vec,
   output logic                     hit,
   output logic                     is_dbe,
   output logic [LANE_W-1:0]        lane,
   output logic [SYN_W-1:0]         syn
);

   logic [LANE_W-1:0] d_idx;
   logic [LANE_W-1:0] s_idx;

   // descending scan leaves the lowest flagged lane
   always_comb begin
      d_idx = '0;
      s_idx = '0;
      for (int i = N_LANES-1; i >= 0; i--) begin
         if (dbe[i]) d_idx = LANE_W'(i);
         if (sbe[i]) s_idx = LANE_W'(i);
      end
   end

   assign is_dbe = |dbe;
   assign hit    = (|dbe) || (|sbe);
   assign lane   = is_dbe ? d_idx : s_idx;
   assign syn    = syn_vec[lane*SYN_W +: SYN_W];

endmodule

// File: rtl/ecc_corrupt_gen.sv
module ecc_corrupt_gen #(
   parameter int SYN_W = 8,
   localparam int POS_W = (SYN_W > 1) ? $clog2(SYN_W) : 1
) (
   input  logic             en,
   input  logic             dbl,
   input  logic [POS_W-1:0] pos_a,
   input  logic [POS_W-1:0] pos_b,
   output logic [SYN_W-1:0] mask
);

   for (genvar b = 0; b < SYN_W; b++) begin : g_bit
      assign mask[b] = en && ((pos_a == POS_W'(b)) || (dbl && (pos_b == POS_W'(b))));
   end

endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor #(
   parameter int N_LANES = 4,
   parameter int DATA_W  = 64,
   parameter int CODE_W  = 72,
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rd_valid,
   input  logic [ADDR_W-1:0]                 rd_addr,
   input  logic [N_LANES-1:0]                lane_sbe,
   input  logic [N_LANES-1:0]                lane_dbe,
   input  logic [N_LANES*(CODE_W-DATA_W)-1:0] lane_syn,
   output logic [N_LANES-1:0]                word_err,
   input  logic                              reg_we,
   input  logic [3:0]                        reg_addr,
   input  logic [31:0]                       reg_wdata,
   output logic [31:0]                       reg_rdata,
   output logic                              irq,
   output logic                              corrupt_en,
   output logic [CODE_W-DATA_W-1:0]          corrupt_mask
);
   import ecc_mon_pkg::*;

   localparam int SYN_W  = CODE_W - DATA_W;
   localparam int POS_W  = (SYN_W > 1) ? $clog2(SYN_W) : 1;
   localparam int LANE_W = (N_LANES > 1) ? $clog2(N_LANES) : 1;

   if (N_LANES < 1 || N_LANES > 256) begin : g_bad_lanes
      $error("ecc_err_monitor: N_LANES must be 1..256");
   end
   if (SYN_W < 2 || SYN_W > 8) begin : g_bad_syn
      $error("ecc_err_monitor: check-bit count must be 2..8");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ecc_err_monitor: ADDR_W must be 1..32");
   end
   if (CNT_W < 1 || CNT_W > 32 || (2**CNT_W) <= N_LANES) begin : g_bad_cnt
      $error("ecc_err_monitor: CNT_W out of range for N_LANES");
   end

   // register write decode
   logic wr_ctrl, wr_istat, wr_imask, wr_sthr, wr_dthr, wr_cclr, wr_cinfo;
   assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
   assign wr_istat = reg_we && (reg_addr == RA_ISTAT);
   assign wr_imask = reg_we && (reg_addr == RA_IMASK);
   assign wr_sthr  = reg_we && (reg_addr == RA_STHR);
   assign wr_dthr  = reg_we && (reg_addr == RA_DTHR);
   assign wr_cclr  = reg_we && (reg_addr == RA_CCLR);
   assign wr_cinfo = reg_we && (reg_addr == RA_CINFO);

   // configuration state
   logic                 recent_q, cor_on_q, cor_dbl_q;
   logic [POS_W-1:0]     pos_a_q, pos_b_q;
   logic [IRQ_SRC_N-1:0] imask_q, istat_q;
   logic [CNT_W-1:0]     sthr_q, dthr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recent_q  <= 1'b0;
         cor_on_q  <= 1'b0;
         cor_dbl_q <= 1'b0;
         pos_a_q   <= '0;
         pos_b_q   <= '0;
         imask_q   <= '0;
         sthr_q    <= '0;
         dthr_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            recent_q  <= reg_wdata[CB_RECENT];
            cor_on_q  <= reg_wdata[CB_COR_ON];
            cor_dbl_q <= reg_wdata[CB_COR_DB];
            pos_a_q   <= reg_wdata[CB_POS_A +: POS_W];
            pos_b_q   <= reg_wdata[CB_POS_B +: POS_W];
         end
         if (wr_imask) imask_q <= reg_wdata[IRQ_SRC_N-1:0];
         if (wr_sthr)  sthr_q  <= reg_wdata[CNT_W-1:0];
         if (wr_dthr)  dthr_q  <= reg_wdata[CNT_W-1:0];
      end
   end

   // qualified per-lane events
   logic [N_LANES-1:0] sbe_ev, dbe_ev;
   assign dbe_ev   = lane_dbe & {N_LANES{rd_valid}};
   assign sbe_ev   = lane_sbe & ~lane_dbe & {N_LANES{rd_valid}};
   assign word_err = dbe_ev;

   // counters
   logic [CNT_W-1:0] sbe_cnt, dbe_cnt;
   logic             s_cross, d_cross;

   ecc_err_count #(.N_IN(N_LANES), .CNT_W(CNT_W)) u_scnt (
      .clk(clk), .rst_n(rst_n), .inc(sbe_ev), .clr(wr_cclr),
      .thresh(sthr_q), .count(sbe_cnt), .crossed(s_cross)
   );

   ecc_err_count #(.N_IN(N_LANES), .CNT_W(CNT_W)) u_dcnt (
      .clk(clk), .rst_n(rst_n), .inc(dbe_ev), .clr(wr_cclr),
      .thresh(dthr_q), .count(dbe_cnt), .crossed(d_cross)
   );

   // pending interrupt bits: set wins over write-one-to-clear
   logic [IRQ_SRC_N-1:0] pend_set, pend_clr;
   always_comb begin
      pend_set          = '0;
      pend_set[PB_SBE]  = |sbe_ev;
      pend_set[PB_DBE]  = |dbe_ev;
      pend_set[PB_SCRS] = s_cross;
      pend_set[PB_DCRS] = d_cross;
      pend_clr          = wr_istat ? reg_wdata[IRQ_SRC_N-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) istat_q <= '0;
      else        istat_q <= (istat_q & ~pend_clr) | pend_set;
   end

   assign irq = |(istat_q & imask_q);

   // capture
   logic              sel_hit, sel_dbe;
   logic [LANE_W-1:0] sel_lane;
   logic [SYN_W-1:0]  sel_syn;

   ecc_err_select #(.N_LANES(N_LANES), .SYN_W(SYN_W)) u_sel (
      .sbe(sbe_ev), .dbe(dbe_ev), .syn_vec(lane_syn),
      .hit(sel_hit), .is_dbe(sel_dbe), .lane(sel_lane), .syn(sel_syn)
   );

   logic              cap_valid_q, cap_dbe_q;
   logic [LANE_W-1:0] cap_lane_q;
   logic [SYN_W-1:0]  cap_syn_q;
   logic [ADDR_W-1:0] cap_addr_q;
   logic              cap_take;

   assign cap_take = sel_hit && (recent_q || !cap_valid_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid_q <= 1'b0;
         cap_dbe_q   <= 1'b0;
         cap_lane_q  <= '0;
         cap_syn_q   <= '0;
         cap_addr_q  <= '0;
      end else if (cap_take) begin
         cap_valid_q <= 1'b1;
         cap_dbe_q   <= sel_dbe;
         cap_lane_q  <= sel_lane;
         cap_syn_q   <= sel_syn;
         cap_addr_q  <= rd_addr;
      end else if (wr_cinfo && reg_wdata[0]) begin
         cap_valid_q <= 1'b0;
      end
   end

   // corruption control
   ecc_corrupt_gen #(.SYN_W(SYN_W)) u_cor (
      .en(cor_on_q), .dbl(cor_dbl_q), .pos_a(pos_a_q), .pos_b(pos_b_q),
      .mask(corrupt_mask)
   );
   assign corrupt_en = cor_on_q;

   // register read
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CB_RECENT]          = recent_q;
            reg_rdata[CB_COR_ON]          = cor_on_q;
            reg_rdata[CB_COR_DB]          = cor_dbl_q;
            reg_rdata[CB_POS_A +: POS_W]  = pos_a_q;
            reg_rdata[CB_POS_B +: POS_W]  = pos_b_q;
         end
         RA_ISTAT: reg_rdata[IRQ_SRC_N-1:0] = istat_q;
         RA_IMASK: reg_rdata[IRQ_SRC_N-1:0] = imask_q;
         RA_STHR:  reg_rdata[CNT_W-1:0]     = sthr_q;
         RA_DTHR:  reg_rdata[CNT_W-1:0]     = dthr_q;
         RA_SCNT:  reg_rdata[CNT_W-1:0]     = sbe_cnt;
         RA_DCNT:  reg_rdata[CNT_W-1:0]     = dbe_cnt;
         RA_CADDR: reg_rdata[ADDR_W-1:0]    = cap_addr_q;
         RA_CINFO: begin
            reg_rdata[0]     = cap_valid_q;
            reg_rdata[1]     = cap_dbe_q;
            reg_rdata[15:8]  = 8'(cap_syn_q);
            reg_rdata[23:16] = 8'(cap_lane_q);
         end
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ecc_err_monitor_chk.sv
module ecc_err_monitor_chk #(
   parameter int N_LANES = 4,
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int SYN_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_valid,
   input logic [N_LANES-1:0] lane_dbe,
   input logic [N_LANES-1:0] word_err,
   input logic               reg_we,
   input logic [3:0]         reg_addr,
   input logic               irq,
   input logic [CNT_W-1:0]   sbe_cnt,
   input logic [CNT_W-1:0]   dbe_cnt,
   input logic [3:0]         istat,
   input logic               recent,
   input logic               cap_valid,
   input logic [ADDR_W-1:0]  cap_addr,
   input logic               corrupt_en,
   input logic [SYN_W-1:0]   corrupt_mask
);
   import ecc_mon_pkg::*;

   AST_WORD_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (|word_err) |-> rd_valid) else $error("word_err without read"); // R2

   AST_SBE_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == RA_CCLR) |=> (sbe_cnt >= $past(sbe_cnt))) else $error("sbe count fell"); // R1

   AST_DBE_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == RA_CCLR) |=> (dbe_cnt >= $past(dbe_cnt))) else $error("dbe count fell"); // R1

   AST_DBE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (|lane_dbe)) |=> istat[1]) else $error("dbe pending not set"); // R3

   AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_we && (reg_addr == RA_ISTAT || reg_addr == RA_IMASK)))
      else $error("irq dropped without software write"); // R5

   AST_CAP_LOCKED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !recent && !(reg_we && reg_addr == RA_CINFO)) |=> $stable(cap_addr))
      else $error("locked capture changed"); // R6

   AST_CORRUPT_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      corrupt_en |-> ($countones(corrupt_mask) == 1 || $countones(corrupt_mask) == 2))
      else $error("corrupt mask weight"); // R8

   AST_CORRUPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !corrupt_en |-> (corrupt_mask == '0)) else $error("corrupt mask while off"); // R8

endmodule

bind ecc_err_monitor ecc_err_monitor_chk #(
   .N_LANES(N_LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYN_W(CODE_W - DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .lane_dbe(lane_dbe),
   .word_err(word_err), .reg_we(reg_we), .reg_addr(reg_addr), .irq(irq),
   .sbe_cnt(sbe_cnt), .dbe_cnt(dbe_cnt), .istat(istat_q), .recent(recent_q),
   .cap_valid(cap_valid_q), .cap_addr(cap_addr_q), .corrupt_en(corrupt_en),
   .corrupt_mask(corrupt_mask)
);

// File: tb/ecc_err_monitor_bench.sv
`timescale 1ns/1ps
module ecc_err_monitor_bench;

   localparam int NL = 3;
   localparam int AW = 16;
   localparam int CW = 4;
   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [NL-1:0] lane_sbe = '0;
   logic [NL-1:0] lane_dbe = '0;
   logic [NL*SW-1:0] lane_syn = '0;
   logic [NL-1:0] word_err;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;
   logic          corrupt_en;
   logic [SW-1:0] corrupt_mask;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ecc_err_monitor #(.N_LANES(NL), .DATA_W(64), .CODE_W(72), .ADDR_W(AW), .CNT_W(CW)) u_ecc_err_monitor (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .lane_sbe(lane_sbe), .lane_dbe(lane_dbe), .lane_syn(lane_syn),
      .word_err(word_err), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .corrupt_en(corrupt_en), .corrupt_mask(corrupt_mask)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd(input logic [NL-1:0] s, input logic [NL-1:0] dd, input logic [AW-1:0] a);
      @(negedge clk);
      rd_valid = 1'b1; lane_sbe = s; lane_dbe = dd; rd_addr = a;
      @(negedge clk);
      rd_valid = 1'b0; lane_sbe = '0; lane_dbe = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 10; i++) begin
         rdreg(4'(i), v);
         check($sformatf("R9 reset reg %0d", i), v, 32'h0);
      end
      check("R5 reset irq", {31'b0, irq}, 32'h0);
      check("R8 reset mask", {24'b0, corrupt_mask}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(4'h0, 32'h0000_7301);
      rdreg(4'h0, v); check("R9 ctrl readback", v, 32'h0000_7301);
      wr(4'h0, 32'h0);
      wr(4'h2, 32'hFFFF_FFFF);
      rdreg(4'h2, v); check("R9 mask field", v, 32'h0000_000F);
      wr(4'h2, 32'h0);
      wr(4'h3, 32'h0000_1234);
      rdreg(4'h3, v); check("R9 threshold field", v, 32'h0000_0004);
      rdreg(4'hC, v); check("R9 unmapped", v, 32'h0);
   endtask

   task automatic t_word_err();
      logic [31:0] v;
      @(negedge clk);
      rd_valid = 1'b1; lane_dbe = 3'b101; lane_sbe = 3'b010;
      #1 check("R2 flags with read", {29'b0, word_err}, 32'h5);
      rd_valid = 1'b0; lane_dbe = 3'b111;
      #1 check("R2 quiet without read", {29'b0, word_err}, 32'h0);
      @(negedge clk);
      lane_dbe = '0; lane_sbe = '0;
      rdreg(4'h6, v); check("R1 no count without strobe", v, 32'h0);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(4'h7, 32'h0);
      wr(4'h1, 32'hF);
      wr(4'h3, 32'h2);
      rd(3'b101, 3'b000, 16'h0);
      rdreg(4'h5, v); check("R1 sbe count two lanes", v, 32'h2);
      rdreg(4'h1, v); check("R4 no crossing at threshold", v, 32'h1);
      rd(3'b010, 3'b000, 16'h0);
      rdreg(4'h1, v); check("R4 sbe crossing", v, 32'h5);
      rd(3'b011, 3'b001, 16'h0);
      rdreg(4'h5, v); check("R1 dbe lane not single", v, 32'h4);
      rdreg(4'h6, v); check("R1 dbe count", v, 32'h1);
      rdreg(4'h1, v); check("R3 R4 all pending", v, 32'hF);
      wr(4'h1, 32'h5);
      rdreg(4'h1, v); check("R3 write one clears", v, 32'hA);
   endtask

   task automatic t_saturate();
      logic [31:0] v;
      wr(4'h7, 32'h0);
      for (int k = 0; k < 6; k++) rd(3'b111, 3'b000, 16'h0);
      rdreg(4'h5, v); check("R1 saturate", v, 32'hF);
      wr(4'h7, 32'h0);
      rdreg(4'h5, v); check("R1 clear sbe", v, 32'h0);
      rdreg(4'h6, v); check("R1 clear dbe", v, 32'h0);
   endtask

   task automatic t_irq();
      wr(4'h1, 32'hF);
      rd(3'b000, 3'b100, 16'h0);
      check("R5 masked off", {31'b0, irq}, 32'h0);
      wr(4'h2, 32'h2);
      check("R5 dbe enabled", {31'b0, irq}, 32'h1);
      wr(4'h1, 32'h2);
      check("R5 cleared source", {31'b0, irq}, 32'h0);
      wr(4'h2, 32'h8);
      check("R5 crossing source", {31'b0, irq}, 32'h1);
      wr(4'h2, 32'h0);
      wr(4'h1, 32'hF);
   endtask

   task automatic t_capture();
      logic [31:0] v;
      lane_syn = {8'h33, 8'h22, 8'h11};
      wr(4'h0, 32'h0);
      wr(4'h9, 32'h1);
      rd(3'b110, 3'b000, 16'h1234);
      rdreg(4'h9, v); check("R7 lowest single lane", v, 32'h0001_2201);
      rdreg(4'h8, v); check("R7 address", v, 32'h0000_1234);
      rd(3'b011, 3'b100, 16'h5678);
      rdreg(4'h8, v); check("R6 first locked addr", v, 32'h0000_1234);
      rdreg(4'h9, v); check("R6 first locked info", v, 32'h0001_2201);
      wr(4'h9, 32'h1);
      rdreg(4'h9, v); check("R6 valid cleared", v, 32'h0001_2200);
      rd(3'b001, 3'b110, 16'hBEEF);
      rdreg(4'h9, v); check("R7 double outranks", v, 32'h0001_2203);
      rdreg(4'h8, v); check("R7 double address", v, 32'h0000_BEEF);
      wr(4'h0, 32'h1);
      rd(3'b100, 3'b000, 16'h0042);
      rdreg(4'h9, v); check("R6 recent overwrite", v, 32'h0002_3301);
      rd(3'b001, 3'b000, 16'h0007);
      rdreg(4'h8, v); check("R6 recent address", v, 32'h0000_0007);
      rdreg(4'h9, v); check("R6 recent info", v, 32'h0000_1101);
   endtask

   task automatic t_corrupt();
      wr(4'h0, 32'h0000_0502);
      check("R8 enable", {31'b0, corrupt_en}, 32'h1);
      check("R8 single bit", {24'b0, corrupt_mask}, 32'h20);
      wr(4'h0, 32'h0000_2506);
      check("R8 two bits", {24'b0, corrupt_mask}, 32'h24);
      wr(4'h0, 32'h0000_3306);
      check("R8 equal positions", {24'b0, corrupt_mask}, 32'h08);
      wr(4'h0, 32'h0000_0504);
      check("R8 disabled mask", {24'b0, corrupt_mask}, 32'h00);
      check("R8 disabled flag", {31'b0, corrupt_en}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_word_err();
      t_count();
      t_saturate();
      t_irq();
      t_capture();
      t_corrupt();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule